// File: doc/BRIEF.md
# Programmable Watchdog with Expiry Steering

This block is a watchdog timer driven by one byte-wide control register. The register carries a five-bit multiplier, a two-bit resolution code and a steering bit. Timeout is measured in ticks of an external strobe that pulses once per sixteenth of a second. Software keeps the watchdog alive by writing the register or by reading it back, and either access restarts the countdown.

The steering bit selects what happens when the count runs out. With the bit set, the block issues a one-cycle reset request. It also zeroes its own control register and pulses a clear strobe for the century bit of a neighbouring date register. With the bit clear, the block issues a single interrupt pulse and holds the count until software next touches the register. In both cases a sticky expiry flag is raised in the flags byte, and the next restart clears it.

The controller is a three-state machine. In `WD_IDLE` the watchdog is disabled. In `WD_RUN` it is counting. In `WD_HALT` it has expired through the interrupt path. A restart moves any state to `WD_RUN` when the loaded timeout is non-zero, and to `WD_IDLE` otherwise. An expiry moves `WD_RUN` to `WD_IDLE` when steered to reset, and to `WD_HALT` when steered to interrupt. Without a restart, `WD_IDLE` and `WD_HALT` stay where they are.

Top module: `wdg_steer_top`

## Requirements
- R1: After reset the control register reads 0x00, the flags byte is 0x00, all three pulse outputs are low, and no tick causes an expiry until the register is accessed.
- R2: The timeout T equals multiplier × 4^resolution ticks. The multiplier is bits 6:2 of the register and the resolution is bits 1:0. When a restart is sampled at clock edge E, the expiry happens on the T-th tick sampled after E, and the pulse output is high during the cycle that follows that edge.
- R3: A register value whose multiplier field is zero, including 0x00, disables the watchdog, so no expiry occurs however many ticks arrive.
- R4: A write stores the byte, restarts the countdown from the new value and clears the expiry flag.
- R5: A read returns the stored byte on `reg_rdata`, restarts the countdown from the stored value and clears the expiry flag.
- R6: On expiry with bit 7 of the register set, `rst_req_o` and `cent_clr_o` are each high for exactly one cycle, the register becomes 0x00, and flag bit 7 is set.
- R7: On expiry with bit 7 clear, `irq_o` is high for exactly one cycle, flag bit 7 is set, and the register keeps its value. No further expiry occurs until the next read or write.
- R8: A restart in the same cycle as an expiring tick takes priority, so no pulse is issued. A write together with a read acts as a write.
- R9: Flags bits 6:0 always read zero. `rst_req_o` and `irq_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_rd | input | 1 | Read strobe for the control register (restarts the count) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current control register value |
| tick_i | input | 1 | One-cycle strobe per 1/16 s tick |
| rst_req_o | output | 1 | One-cycle reset request on a reset-steered expiry |
| irq_o | output | 1 | One-cycle interrupt on an interrupt-steered expiry |
| cent_clr_o | output | 1 | One-cycle clear strobe for the companion century bit |
| flags_o | output | 8 | Flags byte; bit 7 is the expiry flag |

## Verification
The assertions assume that `reg_wr`, `reg_rd` and `tick_i` are plain synchronous strobes with no X values after reset. They also assume a read samples the register it restarts from, so a read and a write in one cycle must resolve to the write. The stimulus changes every input only at falling edges. It keeps the tick strobe either continuously high or as isolated single-cycle pulses, so each expected expiry cycle follows directly from the timeout formula. The bench never reads the register in the cycle that a reset-steered expiry clears it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_HALT = 2'd2
    } wd_state_t;
endpackage

// File: rtl/wdg_decode.sv
// Turns a register image into a tick count: multiplier scaled by 4^resolution.
module wdg_decode #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int REG_W  = MULT_W + RES_W + 1,
    parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic [REG_W-1:0] val_i,
    output logic [CNT_W-1:0] load_o,
    output logic             off_o
);
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;

    always_comb begin
        res    = val_i[RES_W-1:0];
        mult   = val_i[RES_W +: MULT_W];
        load_o = CNT_W'(mult) << (2 * res);
        off_o  = (mult == '0);
    end
endmodule

// File: rtl/wdg_counter.sv
// Down counter of remaining ticks.
module wdg_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (load_i) begin
            cnt_o <= load_val_i;
        end else if (dec_i) begin
            cnt_o <= cnt_o - 1'b1;
        end
    end

    assign last_o = (cnt_o == CNT_W'(1));

    // R2
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i && !load_i |-> cnt_o != '0);
endmodule

// File: rtl/wdg_fsm.sv
// Watchdog controller: state register, next state, registered pulse outputs.
module wdg_fsm
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart_i,
    input  logic      restart_off_i,
    input  logic      tick_i,
    input  logic      last_i,
    input  logic      steer_i,
    output logic      dec_o,
    output logic      fire_o,
    output logic      rst_req_o,
    output logic      irq_o,
    output logic      cent_clr_o,
    output wd_state_t state_o
);
    wd_state_t state_q, state_d;

    assign fire_o = (state_q == WD_RUN) && tick_i && last_i && !restart_i;
    assign dec_o  = (state_q == WD_RUN) && tick_i && !last_i && !restart_i;
    assign state_o = state_q;

    always_comb begin
        state_d = state_q;
        if (restart_i) begin
            state_d = restart_off_i ? WD_IDLE : WD_RUN;
        end else begin
            unique case (state_q)
                WD_IDLE: state_d = WD_IDLE;
                WD_RUN: begin
                    if (fire_o) state_d = steer_i ? WD_IDLE : WD_HALT;
                end
                WD_HALT: state_d = WD_HALT;
                default: state_d = WD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_req_o  <= 1'b0;
            irq_o      <= 1'b0;
            cent_clr_o <= 1'b0;
        end else begin
            rst_req_o  <= fire_o && steer_i;
            cent_clr_o <= fire_o && steer_i;
            irq_o      <= fire_o && !steer_i;
        end
    end

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req_o && irq_o));
    // R6
    rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
    // R7
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_HALT) && !restart_i |=> state_q == WD_HALT);
endmodule

// File: rtl/wdg_steer_top.sv
module wdg_steer_top
    import wdg_pkg::*;
#(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int FLAG_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [MULT_W+RES_W:0]       reg_wdata,
    output logic [MULT_W+RES_W:0]       reg_rdata,
    input  logic                        tick_i,
    output logic                        rst_req_o,
    output logic                        irq_o,
    output logic                        cent_clr_o,
    output logic [FLAG_W-1:0]           flags_o
);
    localparam int STEER_BIT = MULT_W + RES_W;
    localparam int REG_W     = STEER_BIT + 1;
    localparam int CNT_W     = MULT_W + 2 * ((1 << RES_W) - 1);

    logic [REG_W-1:0] ctl_q;
    logic [REG_W-1:0] src_val;
    logic [CNT_W-1:0] load_val, cnt;
    logic             restart, load_off, last, dec, fire, flag_q;
    wd_state_t        state;

    assign restart = reg_wr || reg_rd;
    assign src_val = reg_wr ? reg_wdata : ctl_q;

    wdg_decode #(.MULT_W(MULT_W), .RES_W(RES_W), .REG_W(REG_W), .CNT_W(CNT_W)) dec_i (
        .val_i (src_val),
        .load_o(load_val),
        .off_o (load_off)
    );

    wdg_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (restart),
        .load_val_i(load_val),
        .dec_i     (dec),
        .cnt_o     (cnt),
        .last_o    (last)
    );

    wdg_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (restart),
        .restart_off_i(load_off),
        .tick_i       (tick_i),
        .last_i       (last),
        .steer_i      (ctl_q[STEER_BIT]),
        .dec_o        (dec),
        .fire_o       (fire),
        .rst_req_o    (rst_req_o),
        .irq_o        (irq_o),
        .cent_clr_o   (cent_clr_o),
        .state_o      (state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (reg_wr) begin
            ctl_q <= reg_wdata;
        end else if (fire && ctl_q[STEER_BIT]) begin
            ctl_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (restart) flag_q <= 1'b0;
        else if (fire)    flag_q <= 1'b1;
    end

    assign reg_rdata = ctl_q;
    assign flags_o   = {flag_q, {(FLAG_W-1){1'b0}}};

    // R6
    rst_clears_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (ctl_q == '0) && flag_q && cent_clr_o);
    // R7
    irq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_q);
    // R4
    restart_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !flag_q);
    // R2
    run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RUN) |-> cnt != '0);
    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_IDLE) && !restart |=> !rst_req_o && !irq_o);
endmodule

// File: tb/wdg_steer_top_tb.sv
`timescale 1ns/1ps
module wdg_steer_top_tb_top;
    typedef struct { int cyc; bit rst; } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0, tick_i = 1'b1;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, flags_o;
    logic       rst_req_o, irq_o, cent_clr_o;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    logic [7:0] model_reg = 8'h00;
    exp_t q[$];
    bit   done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdg_steer_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_i(tick_i),
        .rst_req_o(rst_req_o), .irq_o(irq_o), .cent_clr_o(cent_clr_o),
        .flags_o(flags_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int tmo(input logic [7:0] v);
        return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
    endfunction

    // Driver: one access; queues the expected expiry assuming a tick every cycle.
    task automatic access(input bit wr, input bit rd, input logic [7:0] v, input bit push);
        logic [7:0] eff;
        @(negedge clk);
        eff = wr ? v : model_reg;
        q.delete();
        if (push && tmo(eff) > 0) q.push_back('{cyc + 1 + tmo(eff), eff[7]});
        if (wr) model_reg = v;
        reg_wr = wr; reg_rd = rd; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (q.size() > 0 && q[0].cyc == cyc) begin
                chk(q[0].rst ? "R6 rst_req" : "R7 irq", q[0].rst ? rst_req_o : irq_o, 1);
                chk("R6 cent_clr", cent_clr_o, q[0].rst);
                chk("R9 other pulse", q[0].rst ? irq_o : rst_req_o, 0);
                if (q[0].rst) model_reg = 8'h00;
                void'(q.pop_front());
            end else if (rst_req_o || irq_o || cent_clr_o) begin
                chk("R2 unexpected pulse", {rst_req_o, irq_o, cent_clr_o}, 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout actual=%0d expected=done", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 flags", flags_o, 8'h00);
        chk("R1 pulses", {rst_req_o, irq_o, cent_clr_o}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);            // R1: ticks while idle, monitor sees nothing
        chk("R1 flags idle", flags_o, 8'h00);

        access(1, 0, 8'h0C, 1);                // R7: T=3, interrupt
        drain();
        chk("R7 flag", flags_o, 8'h80);
        chk("R9 low flags", flags_o[6:0], 0);
        chk("R7 reg kept", reg_rdata, 8'h0C);
        repeat (30) @(negedge clk);            // R7: halted, no more pulses
        chk("R7 still flagged", flags_o, 8'h80);

        access(0, 1, 8'h00, 1);                // R5: read restarts with 0x0C
        chk("R5 flag cleared", flags_o, 8'h00);
        chk("R5 rdata", reg_rdata, 8'h0C);
        drain();

        access(1, 0, 8'h85, 1);                // R6: T=4, reset steered
        drain();
        chk("R6 reg cleared", reg_rdata, 8'h00);
        chk("R6 flag", flags_o, 8'h80);

        access(1, 0, 8'h00, 1);                // R3: disabled
        repeat (100) @(negedge clk);
        chk("R3 zero flags", flags_o, 8'h00);
        access(1, 0, 8'h83, 1);                // R3: multiplier zero, res 3
        repeat (150) @(negedge clk);
        chk("R3 mult0 flags", flags_o, 8'h00);

        access(1, 0, 8'h07, 1); drain();       // R2: T=64
        access(1, 0, 8'h0A, 1); drain();       // R2: T=32
        access(1, 0, 8'h86, 1); drain();       // R2/R6: T=16 reset
        chk("R2 reg after reset", reg_rdata, 8'h00);

        access(1, 0, 8'h14, 1);                // R4: T=5, rewrite mid-count
        repeat (2) @(negedge clk);
        access(1, 0, 8'h14, 1);
        drain();

        access(1, 0, 8'h18, 1);                // R5: T=6, read mid-count
        repeat (3) @(negedge clk);
        access(0, 1, 8'h00, 1);
        drain();

        access(1, 0, 8'h0C, 1);                // R8: write on the expiring edge
        @(negedge clk);
        access(1, 0, 8'h0C, 1);
        chk("R8 flag not set", flags_o, 8'h00);
        drain();

        access(1, 0, 8'h85, 0);                // R8: write+read acts as write
        access(1, 1, 8'h0C, 1);
        drain();
        chk("R8 reg", reg_rdata, 8'h0C);

        @(negedge clk); tick_i = 1'b0;         // R2: sparse ticks, T=2
        access(1, 0, 8'h08, 0);
        repeat (3) @(negedge clk);
        tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
        chk("R2 no early irq", flags_o, 8'h00);
        repeat (3) @(negedge clk);
        q.push_back('{cyc + 1, 1'b0});
        tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
        drain();
        chk("R2 sparse flag", flags_o, 8'h80);

        chk("R2 queue empty", q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule